// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block is the host-side master for an 8-bit successive-approximation converter that is reached over a short synchronous serial link. A one-cycle start request carries a 3-bit channel number and a single-ended/differential flag. The controller then drops chip select and runs a serial clock derived from the system clock by a programmable half-period divider. It sends a start bit followed by the four-bit multiplexer word and lets one settling bit go by. It collects the result most significant bit first and then collects the LSB-first replay of the same value, and compares the two copies.

When the exchange is over, chip select and the serial clock are both held high for a fixed number of system clocks so that the converter resets. Only then does the block return the byte with a one-cycle done pulse and a mismatch flag. With the one-wire option, the host's data-in and the converter's data-out share one line, and the host releases its driver as soon as the last address bit has been taken.

The controller uses six named states. IDLE waits for a request, and a request moves it to ADDR. ADDR drives the five address bits and moves to SETTLE on the 5th rising serial edge. SETTLE discards the dummy bit and moves to MSB on the 6th rising edge. MSB samples result bits on rising edges 7 to 14 and moves to LSB on the 14th. LSB samples the replay on rising edges 15 to 21 and moves to HOLD at the end of the high phase that follows the 21st rising edge. HOLD keeps chip select and the clock high for HOLD_CYC cycles, then returns to IDLE and pulses done.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset and while idle, cs_n_o=1, sclk_o=1, busy_o=0, done_o=0 and di_oe_o=0.
- R2: A start_i accepted in IDLE drops cs_n_o and raises busy_o. A start_i seen while busy_o=1 has no effect on the running exchange and produces no extra done pulse.
- R3: Every low and every high serial-clock phase inside a transaction lasts max(half_period_i, MIN_HALF) system clocks. The first low phase begins in the same cycle that cs_n_o falls.
- R4: The host sends, in this order, 1 (start), single_i, chan_i[0], chan_i[2], chan_i[1]. The first bit appears when cs_n_o falls, and each later bit changes only as sclk_o falls, so the converter can sample each one on a rising edge.
- R5: The bit sampled on the 6th rising serial edge is a dummy and does not enter the result.
- R6: The bits sampled from do_i on rising edges 7 to 14 form data_o, most significant bit first.
- R7: The bits on rising edges 15 to 21 are result bits 1 through 7, in that order. If any of them differs from the MSB-first copy, mismatch_o is 1 in the cycle of done_o. data_o still carries the MSB-first value in that case.
- R8: With one_wire_i=1, di_oe_o falls at the falling serial edge after the 5th rising edge and stays low for the rest of the exchange. With one_wire_i=0, di_oe_o stays high until cs_n_o rises.
- R9: Each exchange has exactly 21 rising serial edges. After the last one, cs_n_o rises at the end of the high phase, and sclk_o stays high while cs_n_o is high. done_o is a one-cycle pulse that comes HOLD_CYC cycles after cs_n_o rises, and busy_o stays high until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run one conversion |
| chan_i | input | 3 | Channel number, or pair number and polarity |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| one_wire_i | input | 1 | 1 = data-in and data-out share one line |
| half_period_i | input | DIV_W | Serial clock half period in system clocks |
| do_i | input | 1 | Serial data returned by the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data sent to the converter |
| di_oe_o | output | 1 | Output enable for di_o on a shared line |
| busy_o | output | 1 | Exchange or reset hold in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| mismatch_o | output | 1 | Two result copies disagreed, valid with done_o |
| data_o | output | 8 | Converted byte, held until the next done |

## Verification
A behavioural converter model on the bench decodes the five address bits it receives and returns a chosen byte in both orders. Both single-ended and differential addressing are used, with odd and even channel numbers, so that a swap between the polarity bit and the select bits shows up in the decoded word. The returned bytes 0x00, 0xFF, 0xA5, 0x3C and 0x81 separate a result shifted by one position, with the dummy bit included, from a correct one. A corrupted replay bit shows that only the LSB-first copy feeds the mismatch flag. Runs in one-wire mode with several divider settings, including one below the minimum, test the line turnaround point and the phase lengths. A second start request in the middle of an exchange shows whether the block ignores it.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETTLE,
        ST_MSB,
        ST_LSB,
        ST_HOLD
    } hst_state_t;

    localparam int ADDR_BITS = 5;
    localparam int RES_BITS  = 8;
    localparam int TAIL_BITS = RES_BITS - 1;
    localparam int RISE_ADDR_LAST = ADDR_BITS;
    localparam int RISE_MSB_LAST  = ADDR_BITS + 1 + RES_BITS;
    localparam int RISE_LAST      = RISE_MSB_LAST + TAIL_BITS;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] hp_eff;

    always_comb begin
        hp_eff = (half_period < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_period;
        tick   = run && (cnt == hp_eff - DIV_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < hp_eff));

endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_msb,
    input  logic             shift_lsb,
    input  logic             bit_in,
    output logic [RES_W-1:0] result,
    output logic             mismatch
);
    localparam int TW = RES_W - 1;

    logic [TW-1:0] tail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            tail   <= '0;
        end else if (clear) begin
            result <= '0;
            tail   <= '0;
        end else begin
            if (shift_msb)
                result <= {result[RES_W-2:0], bit_in};
            if (shift_lsb)
                tail <= {bit_in, tail[TW-1:1]};
        end
    end

    assign mismatch = (tail != result[RES_W-1:1]);

    // R7
    capture_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_msb && shift_lsb));

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 2,
    parameter int HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       chan_i,
    input  logic             single_i,
    input  logic             one_wire_i,
    input  logic [DIV_W-1:0] half_period_i,
    input  logic             do_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             di_o,
    output logic             di_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             mismatch_o,
    output logic [7:0]       data_o
);
    localparam int HW = $clog2(HOLD_CYC) + 1;

    hst_state_t state, state_nx;
    logic [4:0]    rise_cnt;
    logic [HW-1:0] hold_cnt;
    logic [3:0]    addr_sh;
    logic          ow_q;
    logic          run, tick, rise_evt, fall_evt;
    logic          accept, shift_msb, shift_lsb, cap_mis;
    logic [7:0]    cap_res;

    assign run      = (state == ST_ADDR) || (state == ST_SETTLE) ||
                      (state == ST_MSB)  || (state == ST_LSB);
    assign rise_evt = tick && !sclk_o;
    assign fall_evt = tick && sclk_o;
    assign accept   = (state == ST_IDLE) && start_i;
    assign shift_msb = (state == ST_MSB) && rise_evt;
    assign shift_lsb = (state == ST_LSB) && rise_evt;
    assign busy_o   = (state != ST_IDLE);

    adc_sclk_div #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run),
        .half_period(half_period_i), .tick(tick)
    );

    adc_rx_capture #(.RES_W(RES_BITS)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .shift_msb(shift_msb), .shift_lsb(shift_lsb), .bit_in(do_i),
        .result(cap_res), .mismatch(cap_mis)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_i) state_nx = ST_ADDR;
            ST_ADDR:   if (rise_evt && rise_cnt == 5'(RISE_ADDR_LAST - 1)) state_nx = ST_SETTLE;
            ST_SETTLE: if (rise_evt) state_nx = ST_MSB;
            ST_MSB:    if (rise_evt && rise_cnt == 5'(RISE_MSB_LAST - 1)) state_nx = ST_LSB;
            ST_LSB:    if (fall_evt && rise_cnt == 5'(RISE_LAST)) state_nx = ST_HOLD;
            ST_HOLD:   if (hold_cnt == HW'(HOLD_CYC - 1)) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o     <= 1'b1;
            sclk_o     <= 1'b1;
            di_o       <= 1'b0;
            di_oe_o    <= 1'b0;
            done_o     <= 1'b0;
            mismatch_o <= 1'b0;
            data_o     <= '0;
            rise_cnt   <= '0;
            hold_cnt   <= '0;
            addr_sh    <= '0;
            ow_q       <= 1'b0;
        end else begin
            done_o     <= 1'b0;
            mismatch_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cs_n_o   <= 1'b0;
                        sclk_o   <= 1'b0;
                        di_o     <= 1'b1;
                        di_oe_o  <= 1'b1;
                        addr_sh  <= {single_i, chan_i[0], chan_i[2], chan_i[1]};
                        ow_q     <= one_wire_i;
                        rise_cnt <= '0;
                    end
                end
                ST_ADDR, ST_SETTLE, ST_MSB, ST_LSB: begin
                    if (state == ST_LSB && fall_evt && rise_cnt == 5'(RISE_LAST)) begin
                        cs_n_o   <= 1'b1;
                        di_oe_o  <= 1'b0;
                        di_o     <= 1'b0;
                        hold_cnt <= '0;
                    end else if (tick) begin
                        sclk_o <= ~sclk_o;
                        if (rise_evt)
                            rise_cnt <= rise_cnt + 5'd1;
                        if (fall_evt) begin
                            if (rise_cnt < 5'(RISE_ADDR_LAST)) begin
                                di_o    <= addr_sh[3];
                                addr_sh <= {addr_sh[2:0], 1'b0};
                            end else begin
                                di_o <= 1'b0;
                                if (ow_q) di_oe_o <= 1'b0;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    hold_cnt <= hold_cnt + HW'(1);
                    if (hold_cnt == HW'(HOLD_CYC - 1)) begin
                        done_o     <= 1'b1;
                        mismatch_o <= cap_mis;
                        data_o     <= cap_res;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
    // R2
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);
    // R8
    line_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ow_q && (state == ST_MSB || state == ST_LSB)) |-> !di_oe_o);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    mismatch_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> done_o);

endmodule

// File: tb/test_adc_host_ctrl.sv
`timescale 1ns/1ps
module test_adc_host_ctrl;
    localparam int DIV_W = 8, MIN_HALF = 2, HOLD_CYC = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, single_i = 0, one_wire_i = 0, do_i;
    logic [2:0] chan_i = 0;
    logic [DIV_W-1:0] half_period_i = 3;
    logic cs_n_o, sclk_o, di_o, di_oe_o, busy_o, done_o, mismatch_o;
    logic [7:0] data_o;

    always #2 clk = ~clk;

    // converter model
    logic [7:0] conv_val = 0;
    bit   corrupt = 0;
    int   rises = 0;
    logic [4:0] addr_rx = 0;
    logic conv_do = 0;
    logic line;
    assign line = di_oe_o ? di_o : conv_do;
    assign do_i = one_wire_i ? line : conv_do;

    int total = 0, bad = 0;
    int cyc = 0, last_t = -1, cs_rise_t = 0, exp_phase = 3;
    logic prev_sclk = 1, prev_cs = 1;
    int q_data[$], q_err[$], q_addr[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(negedge cs_n_o) begin
        rises = 0; addr_rx = 0; conv_do = 0;
    end

    always @(posedge sclk_o) if (!cs_n_o) begin
        rises++;
        if (rises <= 5) addr_rx = {addr_rx[3:0], (one_wire_i ? line : di_o)};
        if (one_wire_i && rises >= 6)
            chk(!di_oe_o, "R8 one-wire line released", di_oe_o, 0);
        if (!one_wire_i && rises == 21)
            chk(di_oe_o, "R8 four-wire driver kept", di_oe_o, 1);
    end

    always @(negedge sclk_o) if (!cs_n_o && rises >= 5) begin
        if (rises == 5)       conv_do = 1'b0;
        else if (rises <= 13) conv_do = conv_val[7-(rises-6)];
        else if (rises <= 20) conv_do = conv_val[rises-13] ^ (corrupt && rises == 16);
    end

    // monitor
    always @(negedge clk) if (rst_n) begin
        if (sclk_o != prev_sclk && !cs_n_o) begin
            if (last_t >= 0)
                chk(cyc - last_t == exp_phase, "R3 phase length", cyc - last_t, exp_phase);
            last_t = cyc;
        end
        if (cs_n_o) last_t = -1;
        if (cs_n_o && !prev_cs) cs_rise_t = cyc;
        if (cs_n_o && busy_o && !sclk_o)
            chk(0, "R9 sclk high during hold", sclk_o, 1);
        if (done_o) begin
            if (q_data.size() == 0) chk(0, "R2 unexpected done", 1, 0);
            else begin
                int ed, ee, ea;
                ed = q_data.pop_front(); ee = q_err.pop_front(); ea = q_addr.pop_front();
                chk(data_o == ed, "R6 R5 result byte", data_o, ed);
                chk(mismatch_o == ee, "R7 mismatch flag", mismatch_o, ee);
                chk(addr_rx == ea, "R4 address word", addr_rx, ea);
                chk(rises == 21, "R9 rising edge count", rises, 21);
                chk(cyc - cs_rise_t == HOLD_CYC, "R9 hold length", cyc - cs_rise_t, HOLD_CYC);
            end
        end
        prev_sclk = sclk_o;
        prev_cs = cs_n_o;
    end

    task automatic run_txn(input logic [2:0] ch, input bit sgl, input bit ow,
                           input int hp, input logic [7:0] val, input bit bad_tail,
                           input bit extra_start);
        @(negedge clk);
        conv_val = val; corrupt = bad_tail; one_wire_i = ow;
        half_period_i = DIV_W'(hp);
        exp_phase = (hp < MIN_HALF) ? MIN_HALF : hp;
        q_data.push_back(val);
        q_err.push_back(bad_tail);
        q_addr.push_back({1'b1, sgl, ch[0], ch[2], ch[1]});
        chan_i = ch; single_i = sgl; start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(!cs_n_o && busy_o, "R2 cs falls, busy rises", {cs_n_o, busy_o}, 1);
        if (extra_start) begin
            repeat (20) @(negedge clk);
            chan_i = ~ch; single_i = ~sgl; start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        while (!done_o) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(!busy_o && cs_n_o, "R2 no extra exchange", {busy_o, cs_n_o}, 2);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                // R1
                chk(cs_n_o == 1, "R1 cs_n idle", cs_n_o, 1);
                chk(sclk_o == 1, "R1 sclk idle", sclk_o, 1);
                chk(busy_o == 0, "R1 busy idle", busy_o, 0);
                chk(done_o == 0, "R1 done idle", done_o, 0);
                chk(di_oe_o == 0, "R1 oe idle", di_oe_o, 0);
                run_txn(3'd5, 1, 0, 3, 8'hA5, 0, 0);
                run_txn(3'd2, 0, 0, 0, 8'h00, 0, 0);
                run_txn(3'd7, 1, 1, 2, 8'hFF, 0, 0);
                run_txn(3'd0, 0, 1, 5, 8'h3C, 1, 0);
                run_txn(3'd6, 1, 0, 4, 8'h81, 0, 1);
                run_txn(3'd1, 0, 1, 3, 8'h5A, 1, 1);
                chk(q_data.size() == 0, "R9 all results returned", q_data.size(), 0);
            end
            begin
                repeat (150000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    adc_host_ctrl #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .HOLD_CYC(HOLD_CYC)) i_adc_host_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .single_i(single_i), .one_wire_i(one_wire_i), .half_period_i(half_period_i),
        .do_i(do_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .di_o(di_o),
        .di_oe_o(di_oe_o), .busy_o(busy_o), .done_o(done_o),
        .mismatch_o(mismatch_o), .data_o(data_o)
    );
endmodule